// File: doc/BRIEF.md
# Single-Clock Queue with Hysteresis Watermarks

This block is a first-in first-out buffer in which writer and reader share one clock. It reports its fill state in several ways. Exact flags mark the full and empty states and the states one word away from each. Two watermark flags have separate thresholds for setting and for clearing. A data count is also available and can be narrowed. Registered handshake pulses tell each side, one cycle later, whether its request was taken or refused.

Reads use the standard registered style. When a read is accepted, the oldest word appears on the read data bus in the following cycle. A data-valid pulse marks that cycle. The watermark thresholds come either from elaboration constants or from input ports. Port thresholds are captured only while reset is held low, and a single-threshold mode uses one value for both setting and clearing. A parameter selects synchronous or asynchronous active-low reset. Either kind of reset clears the pointers, the occupancy, the handshake registers and the read data register.

Top module: `hyst_fifo`

## Requirements
- R1: An accepted read (rd_en high while not empty) places the oldest stored word on rd_data in the next cycle, with rd_valid high in that cycle only. Words leave in the order they were written. rd_data holds its value in every cycle that follows no accepted read.
- R2: full is high exactly when the occupancy equals DEPTH, and empty is high exactly when it is 0. A write request while full leaves the stored contents and the occupancy unchanged.
- R3: almost_full is high exactly when the occupancy is DEPTH-1, and almost_empty is high exactly when it is 1.
- R4: prog_full is set when the occupancy becomes at least the full-set threshold. It is cleared only when the occupancy falls below the full-clear threshold, and it holds its value in between.
- R5: prog_empty is set when the occupancy becomes at most the empty-set threshold. It is cleared only when the occupancy rises above the empty-clear threshold, and it holds its value in between.
- R6: In single-threshold mode, each flag's set port also serves as its clear threshold, and the clear ports have no effect.
- R7: Threshold ports are sampled at each clock edge while rst_n is low. Changes made to them after reset is released have no effect.
- R8: wr_ack is high in the cycle after an accepted write. overflow is high in the cycle after a write request refused because the queue was full.
- R9: underflow is high in the cycle after a read request refused because the queue was empty. rd_valid stays low in that cycle and rd_data is unchanged.
- R10: On a full queue, a simultaneous read and write performs only the read and reports overflow. On an empty queue, it performs only the write and reports underflow.
- R11: fill_count equals the occupancy shifted right by (ceil(log2(DEPTH+1)) - COUNT_W) bits, so it keeps the upper bits when narrowed.
- R12: Reset clears the occupancy and the handshake outputs, sets rd_data to 0 and sets prog_empty to 1. In asynchronous mode this takes effect as soon as rst_n falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low reset, synchronous or asynchronous by parameter |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| pf_thr_set | input | CW | Full watermark set level (captured in reset) |
| pf_thr_clr | input | CW | Full watermark clear level (captured in reset) |
| pe_thr_set | input | CW | Empty watermark set level (captured in reset) |
| pe_thr_clr | input | CW | Empty watermark clear level (captured in reset) |
| rd_data | output | DATA_W | Registered read word |
| full | output | 1 | Occupancy equals DEPTH |
| almost_full | output | 1 | Occupancy equals DEPTH-1 |
| prog_full | output | 1 | Full watermark with hysteresis |
| empty | output | 1 | Occupancy is zero |
| almost_empty | output | 1 | Occupancy is one |
| prog_empty | output | 1 | Empty watermark with hysteresis |
| fill_count | output | COUNT_W | Occupancy, least-significant bits dropped when narrowed |
| wr_ack | output | 1 | Previous write accepted |
| overflow | output | 1 | Previous write refused |
| rd_valid | output | 1 | rd_data updated by previous read |
| underflow | output | 1 | Previous read refused |

CW is ceil(log2(DEPTH+1)).

## Verification
The hardest states to reach are the hysteresis bands. In these bands the watermark output depends on the direction from which the occupancy arrived, not on its current value. The stimulus therefore walks the occupancy up past the set level and back down through the band, and then climbs again from below the clear level. It also fills and drains the queue completely, so that it can issue the simultaneous read-and-write at both extremes. A second instance uses the asynchronous reset and single-threshold mode. It shares the stimulus with the first instance, and its reset is pulled mid-cycle so that the immediate clearing can be seen against the synchronous instance.

// File: rtl/hf_pkg.sv
// Shared types and width helpers for the hysteresis queue.
package hf_pkg;
    typedef enum logic {RST_SYNC = 1'b0, RST_ASYNC = 1'b1} hf_rst_e;
    typedef enum logic [1:0] {THR_CONST = 2'd0, THR_PORT_SPLIT = 2'd1, THR_PORT_SINGLE = 2'd2} hf_thr_e;

    // Bits needed to hold an occupancy from 0 to depth.
    function automatic int hf_cnt_w(input int depth);
        return $clog2(depth + 1);
    endfunction

    // Bits needed to address depth storage slots.
    function automatic int hf_ptr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/hf_dreg.sv
// Resettable register whose reset style is chosen by parameter.
// Assumes rst_n is active low; INIT is loaded on reset.
module hf_dreg
    import hf_pkg::*;
#(
    parameter int          W        = 1,
    parameter hf_rst_e     RST_KIND = RST_SYNC,
    parameter logic [W-1:0] INIT    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (RST_KIND == RST_ASYNC) begin : g_async
            // Register with reset acting at once on rst_n falling.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= INIT;
                else        q <= d;
            end
        end else begin : g_sync
            // Register with reset sampled at the clock edge.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= INIT;
                else        q <= d;
            end
        end
    endgenerate
endmodule

// File: rtl/hf_ctrl.sv
// Request arbitration, pointers, occupancy and handshake registers.
// A write is taken only when not full and a read only when not empty,
// both judged on the registered occupancy.
module hf_ctrl
    import hf_pkg::*;
#(
    parameter int      DEPTH    = 16,
    parameter hf_rst_e RST_KIND = RST_SYNC,
    localparam int     CW       = hf_cnt_w(DEPTH),
    localparam int     AW       = hf_ptr_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] occ_nxt,
    output logic          wr_ack,
    output logic          overflow,
    output logic          rd_valid,
    output logic          underflow
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    logic [AW-1:0] wr_ptr_nxt, rd_ptr_nxt;
    logic [3:0]    hs_nxt, hs_q;

    // Acceptance of each request and the next pointer and occupancy values.
    always_comb begin
        wr_go      = wr_en && (occ != FULL_C);
        rd_go      = rd_en && (occ != '0);
        occ_nxt    = occ + CW'(wr_go) - CW'(rd_go);
        wr_ptr_nxt = wr_ptr;
        rd_ptr_nxt = rd_ptr;
        if (wr_go) wr_ptr_nxt = (wr_ptr == LAST_C) ? '0 : wr_ptr + AW'(1);
        if (rd_go) rd_ptr_nxt = (rd_ptr == LAST_C) ? '0 : rd_ptr + AW'(1);
        hs_nxt     = {wr_go, wr_en && !wr_go, rd_go, rd_en && !rd_go};
    end

    hf_dreg #(.W(CW), .RST_KIND(RST_KIND)) u_occ (.clk(clk), .rst_n(rst_n), .d(occ_nxt),    .q(occ));
    hf_dreg #(.W(AW), .RST_KIND(RST_KIND)) u_wp  (.clk(clk), .rst_n(rst_n), .d(wr_ptr_nxt), .q(wr_ptr));
    hf_dreg #(.W(AW), .RST_KIND(RST_KIND)) u_rp  (.clk(clk), .rst_n(rst_n), .d(rd_ptr_nxt), .q(rd_ptr));
    hf_dreg #(.W(4),  .RST_KIND(RST_KIND)) u_hs  (.clk(clk), .rst_n(rst_n), .d(hs_nxt),     .q(hs_q));

    assign {wr_ack, overflow, rd_valid, underflow} = hs_q;

    // R11: occupancy moves by one in the direction the handshakes report.
    a_r11_occ_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !rd_go) |=> (occ == $past(occ) + CW'(1)));
    a_r11_occ_down: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !wr_go) |=> (occ == $past(occ) - CW'(1)));
    // R2 / R10: a write on a full queue is refused and reported.
    a_r2_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == FULL_C && wr_en) |=> (overflow && !wr_ack));
    // R9 / R10: a read on an empty queue is refused and reported.
    a_r9_empty_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && rd_en) |=> (underflow && !rd_valid));
endmodule

// File: rtl/hf_store.sv
// Storage array and registered read-data output.
// Assumes the controller never writes a full array or reads an empty one.
module hf_store
    import hf_pkg::*;
#(
    parameter int      DATA_W   = 8,
    parameter int      DEPTH    = 16,
    parameter hf_rst_e RST_KIND = RST_SYNC,
    localparam int     AW       = hf_ptr_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_go,
    input  logic [AW-1:0]     rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_nxt;

    // Write port of the storage array (no reset needed on contents).
    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr] <= wr_data;
    end

    // Next read word: the addressed slot on a read, otherwise hold.
    always_comb rd_nxt = rd_go ? mem[rd_ptr] : rd_data;

    hf_dreg #(.W(DATA_W), .RST_KIND(RST_KIND)) u_rd (.clk(clk), .rst_n(rst_n), .d(rd_nxt), .q(rd_data));

    // R1: the read word changes only after an accepted read.
    a_r1_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));
endmodule

// File: rtl/hf_flags.sv
// Exact fill flags and the two watermark flags with hysteresis.
// Watermarks are registered from the next occupancy, so they line up with
// the registered occupancy. Assumes clear <= set for full, set <= clear for
// empty, and DEPTH >= 3.
module hf_flags
    import hf_pkg::*;
#(
    parameter int      DEPTH    = 16,
    parameter hf_rst_e RST_KIND = RST_SYNC,
    parameter hf_thr_e THR_MODE = THR_PORT_SPLIT,
    parameter int      PF_SET_C = 12,
    parameter int      PF_CLR_C = 10,
    parameter int      PE_SET_C = 3,
    parameter int      PE_CLR_C = 5,
    localparam int     CW       = hf_cnt_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] occ_nxt,
    input  logic [CW-1:0] pf_set_i,
    input  logic [CW-1:0] pf_clr_i,
    input  logic [CW-1:0] pe_set_i,
    input  logic [CW-1:0] pe_clr_i,
    output logic          full,
    output logic          almost_full,
    output logic          empty,
    output logic          almost_empty,
    output logic          prog_full,
    output logic          prog_empty
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] AF_C   = CW'(DEPTH - 1);

    logic [CW-1:0] pf_set, pf_clr, pe_set, pe_clr;
    logic          pf_nxt, pe_nxt;

    generate
        if (THR_MODE == THR_CONST) begin : g_const
            assign pf_set = CW'(PF_SET_C);
            assign pf_clr = CW'(PF_CLR_C);
            assign pe_set = CW'(PE_SET_C);
            assign pe_clr = CW'(PE_CLR_C);
        end else begin : g_port
            logic [CW-1:0] pf_set_q, pf_clr_q, pe_set_q, pe_clr_q;
            // Capture the threshold ports on every edge while in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pf_set_q <= pf_set_i;
                    pe_set_q <= pe_set_i;
                    pf_clr_q <= (THR_MODE == THR_PORT_SINGLE) ? pf_set_i : pf_clr_i;
                    pe_clr_q <= (THR_MODE == THR_PORT_SINGLE) ? pe_set_i : pe_clr_i;
                end
            end
            assign pf_set = pf_set_q;
            assign pf_clr = pf_clr_q;
            assign pe_set = pe_set_q;
            assign pe_clr = pe_clr_q;
        end
    endgenerate

    // Exact flags decoded from the registered occupancy.
    always_comb begin
        full         = (occ == FULL_C);
        almost_full  = (occ == AF_C);
        empty        = (occ == '0);
        almost_empty = (occ == CW'(1));
    end

    // Hysteresis: set above one level, clear beyond the other, else hold.
    always_comb begin
        if (occ_nxt >= pf_set)      pf_nxt = 1'b1;
        else if (occ_nxt < pf_clr)  pf_nxt = 1'b0;
        else                        pf_nxt = prog_full;
        if (occ_nxt <= pe_set)      pe_nxt = 1'b1;
        else if (occ_nxt > pe_clr)  pe_nxt = 1'b0;
        else                        pe_nxt = prog_empty;
    end

    hf_dreg #(.W(1), .RST_KIND(RST_KIND), .INIT(1'b0)) u_pf (.clk(clk), .rst_n(rst_n), .d(pf_nxt), .q(prog_full));
    hf_dreg #(.W(1), .RST_KIND(RST_KIND), .INIT(1'b1)) u_pe (.clk(clk), .rst_n(rst_n), .d(pe_nxt), .q(prog_empty));

    // R3: at most one of the four exact flags is ever high.
    a_r3_exact_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, almost_full, almost_empty, empty}));
    // R4: the full watermark rises only at or above the set level.
    a_r4_pf_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_full) |-> (occ >= pf_set));
    // R4: the full watermark falls only below the clear level.
    a_r4_pf_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_full) |-> (occ < pf_clr));
    // R5: the empty watermark rises only at or below the set level.
    a_r5_pe_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_empty) |-> (occ <= pe_set));
    // R5: the empty watermark falls only above the clear level.
    a_r5_pe_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_empty) |-> (occ > pe_clr));
endmodule

// File: rtl/hyst_fifo.sv
// Top level: single-clock queue with exact flags, hysteresis watermarks,
// narrowed fill count and one-cycle-late handshakes.
// Assumes COUNT_W <= ceil(log2(DEPTH+1)) and DEPTH >= 3.
module hyst_fifo
    import hf_pkg::*;
#(
    parameter int      DATA_W   = 8,
    parameter int      DEPTH    = 16,
    parameter int      COUNT_W  = hf_cnt_w(DEPTH),
    parameter hf_rst_e RST_KIND = RST_SYNC,
    parameter hf_thr_e THR_MODE = THR_PORT_SPLIT,
    parameter int      PF_SET_C = 12,
    parameter int      PF_CLR_C = 10,
    parameter int      PE_SET_C = 3,
    parameter int      PE_CLR_C = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic [hf_cnt_w(DEPTH)-1:0]   pf_thr_set,
    input  logic [hf_cnt_w(DEPTH)-1:0]   pf_thr_clr,
    input  logic [hf_cnt_w(DEPTH)-1:0]   pe_thr_set,
    input  logic [hf_cnt_w(DEPTH)-1:0]   pe_thr_clr,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         full,
    output logic                         almost_full,
    output logic                         prog_full,
    output logic                         empty,
    output logic                         almost_empty,
    output logic                         prog_empty,
    output logic [COUNT_W-1:0]           fill_count,
    output logic                         wr_ack,
    output logic                         overflow,
    output logic                         rd_valid,
    output logic                         underflow
);
    localparam int CW = hf_cnt_w(DEPTH);
    localparam int AW = hf_ptr_w(DEPTH);

    logic          wr_go, rd_go;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ, occ_nxt;

    hf_ctrl #(.DEPTH(DEPTH), .RST_KIND(RST_KIND)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_go(wr_go), .rd_go(rd_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .occ(occ), .occ_nxt(occ_nxt), .wr_ack(wr_ack), .overflow(overflow),
        .rd_valid(rd_valid), .underflow(underflow)
    );

    hf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RST_KIND(RST_KIND)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_ptr(wr_ptr), .wr_data(wr_data),
        .rd_go(rd_go), .rd_ptr(rd_ptr), .rd_data(rd_data)
    );

    hf_flags #(
        .DEPTH(DEPTH), .RST_KIND(RST_KIND), .THR_MODE(THR_MODE),
        .PF_SET_C(PF_SET_C), .PF_CLR_C(PF_CLR_C), .PE_SET_C(PE_SET_C), .PE_CLR_C(PE_CLR_C)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .occ(occ), .occ_nxt(occ_nxt),
        .pf_set_i(pf_thr_set), .pf_clr_i(pf_thr_clr), .pe_set_i(pe_thr_set), .pe_clr_i(pe_thr_clr),
        .full(full), .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty),
        .prog_full(prog_full), .prog_empty(prog_empty)
    );

    // Narrowed count keeps the most significant occupancy bits.
    assign fill_count = occ[CW-1 -: COUNT_W];
endmodule

// File: tb/test_hyst_fifo.sv
// Bench: behavioural queue model compared with two instances every cycle.
module test_hyst_fifo;
    import hf_pkg::*;

    localparam int DW = 8;
    localparam int DEPTH = 16;
    localparam int CW = 5;
    localparam int CWB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] pfs = 5'd12, pfc = 5'd9, pes = 5'd3, pec = 5'd6;
    logic [CW-1:0] pfs_b = 5'd10, pfc_b = 5'd2, pes_b = 5'd4, pec_b = 5'd13;

    logic [DW-1:0] a_rd, b_rd;
    logic a_full, a_af, a_pf, a_empty, a_ae, a_pe, a_ack, a_ovf, a_vld, a_udf;
    logic b_full, b_af, b_pf, b_empty, b_ae, b_pe, b_ack, b_ovf, b_vld, b_udf;
    logic [CW-1:0]  a_cnt;
    logic [CWB-1:0] b_cnt;

    hyst_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .COUNT_W(CW), .RST_KIND(RST_SYNC),
                .THR_MODE(THR_PORT_SPLIT)) i_hyst_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .pf_thr_set(pfs), .pf_thr_clr(pfc), .pe_thr_set(pes), .pe_thr_clr(pec),
        .rd_data(a_rd), .full(a_full), .almost_full(a_af), .prog_full(a_pf),
        .empty(a_empty), .almost_empty(a_ae), .prog_empty(a_pe), .fill_count(a_cnt),
        .wr_ack(a_ack), .overflow(a_ovf), .rd_valid(a_vld), .underflow(a_udf));

    hyst_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .COUNT_W(CWB), .RST_KIND(RST_ASYNC),
                .THR_MODE(THR_PORT_SINGLE)) i_hyst_fifo_async (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .pf_thr_set(pfs_b), .pf_thr_clr(pfc_b), .pe_thr_set(pes_b), .pe_thr_clr(pec_b),
        .rd_data(b_rd), .full(b_full), .almost_full(b_af), .prog_full(b_pf),
        .empty(b_empty), .almost_empty(b_ae), .prog_empty(b_pe), .fill_count(b_cnt),
        .wr_ack(b_ack), .overflow(b_ovf), .rd_valid(b_vld), .underflow(b_udf));

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model state.
    int  q[$];
    int  m_dout = 0;
    bit  m_vld = 0, m_ack = 0, m_ovf = 0, m_udf = 0;
    bit  m_pf_a = 0, m_pe_a = 1, m_pf_b = 0, m_pe_b = 1;
    int  ta_pfs, ta_pfc, ta_pes, ta_pec, tb_pf, tb_pe;

    // Model update at each rising edge from the inputs driven at the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_dout = 0; m_vld = 0; m_ack = 0; m_ovf = 0; m_udf = 0;
            m_pf_a = 0; m_pe_a = 1; m_pf_b = 0; m_pe_b = 1;
            ta_pfs = pfs; ta_pfc = pfc; ta_pes = pes; ta_pec = pec;
            tb_pf = pfs_b; tb_pe = pes_b;
        end else begin
            int n;
            bit aw, ar;
            n  = q.size();
            aw = wr_en && (n < DEPTH);
            ar = rd_en && (n > 0);
            m_vld = ar;
            if (ar) m_dout = q.pop_front();
            if (aw) q.push_back(int'(wr_data));
            m_ack = aw;
            m_ovf = wr_en && !aw;
            m_udf = rd_en && !ar;
            n = q.size();
            if (n >= ta_pfs) m_pf_a = 1; else if (n < ta_pfc) m_pf_a = 0;
            if (n <= ta_pes) m_pe_a = 1; else if (n > ta_pec) m_pe_a = 0;
            if (n >= tb_pf) m_pf_b = 1; else if (n < tb_pf) m_pf_b = 0;
            if (n <= tb_pe) m_pe_b = 1; else if (n > tb_pe) m_pe_b = 0;
        end
    end

    // Compare every cycle, a quarter period after the rising edge.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            int n;
            n = q.size();
            chk("R1", "a rd_data", a_rd, m_dout);
            chk("R1", "a rd_valid", a_vld, m_vld);
            chk("R2", "a full", a_full, n == DEPTH);
            chk("R2", "a empty", a_empty, n == 0);
            chk("R3", "a almost_full", a_af, n == DEPTH - 1);
            chk("R3", "a almost_empty", a_ae, n == 1);
            chk("R4 R7", "a prog_full", a_pf, m_pf_a);
            chk("R5 R7", "a prog_empty", a_pe, m_pe_a);
            chk("R11", "a fill_count", a_cnt, n);
            chk("R8", "a wr_ack", a_ack, m_ack);
            chk("R8", "a overflow", a_ovf, m_ovf);
            chk("R9", "a underflow", a_udf, m_udf);
            chk("R1", "b rd_data", b_rd, m_dout);
            chk("R11", "b fill_count", b_cnt, n >> 2);
            chk("R6", "b prog_full", b_pf, m_pf_b);
            chk("R6", "b prog_empty", b_pe, m_pe_b);
        end
    end

    int dv = 1;
    task automatic cyc(input bit w, input bit r);
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = DW'(dv);
        if (w) dv++;
    endtask

    task automatic settle();
        @(posedge clk); #5;
    endtask

    bit done = 0;
    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: these late changes must not alter the captured thresholds.
        pfs = 5'd2; pfc = 5'd1; pes = 5'd14; pec = 5'd15;
        pfs_b = 5'd1; pes_b = 5'd15;
        settle();
        // R12: state just after reset.
        chk("R12", "reset count", a_cnt, 0);
        chk("R12", "reset rd_data", a_rd, 0);
        chk("R12", "reset prog_empty", a_pe, 1);
        chk("R12", "reset empty", a_empty, 1);
        // Fill past full: last two writes refused (R2, R8).
        for (int i = 0; i < 18; i++) cyc(1, 0);
        settle();
        chk("R8", "overflow on full", a_ovf, 1);
        cyc(0, 0);
        // R10: read and write together on a full queue.
        cyc(1, 1);
        settle();
        chk("R10", "full both overflow", a_ovf, 1);
        chk("R10", "full both rd_valid", a_vld, 1);
        chk("R10", "full both count", a_cnt, DEPTH - 1);
        // Drain past empty (R9).
        for (int i = 0; i < 17; i++) cyc(0, 1);
        settle();
        chk("R9", "underflow on empty", a_udf, 1);
        // R10: read and write together on an empty queue.
        cyc(1, 1);
        settle();
        chk("R10", "empty both underflow", a_udf, 1);
        chk("R10", "empty both wr_ack", a_ack, 1);
        chk("R10", "empty both count", a_cnt, 1);
        cyc(0, 1);
        // Walk through the hysteresis bands (R4, R5).
        for (int i = 0; i < 13; i++) cyc(1, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1);
        for (int i = 0; i < 3; i++) cyc(1, 0);
        for (int i = 0; i < 9; i++) cyc(0, 1);
        for (int i = 0; i < 5; i++) cyc(1, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1);
        // Biased random phases.
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 150; i++) begin
                int wprob;
                wprob = p[0] ? 30 : 70;
                cyc($urandom_range(99) < wprob, $urandom_range(99) < (100 - wprob));
            end
        end
        cyc(0, 0);
        for (int i = 0; i < 6; i++) cyc(1, 0);
        cyc(0, 0);
        settle();
        // R12: asynchronous instance clears mid-cycle, synchronous one waits.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R12", "async count cleared", b_cnt, 0);
        chk("R12", "async empty", b_empty, 1);
        chk("R12", "async prog_empty", b_pe, 1);
        chk("R12", "sync waits for edge", a_cnt, q.size());
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) cyc(1, 0);
        for (int i = 0; i < 6; i++) cyc(0, 1);
        cyc(0, 0);
        settle();
        settle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule